// File: doc/BRIEF.md
# Byte-Wide Flash Program and Erase Sequencer

This block sits on the host side of a parallel, byte-wide flash bus and carries out one request at a time: write a single byte, or erase the whole chip. A request brings an address, a data byte and an operation flag. The block first plays the unlock and command writes the flash expects. It then reads the device status again and again until the flash reports that it has finished, or until a poll budget runs out.

Every bus cycle is built from whole clocks. A write lowers the write strobe for a parameterised number of clocks. The address and data are set up one clock before the strobe falls and held one clock after it rises. A read keeps chip enable and output enable low for a parameterised number of clocks and takes the data bus on the last of them. The flash has no ready pin, so completion is judged from the status bits. For a byte program, bit 7 is compared with the written data. For either operation, the block checks whether bit 6 has stopped alternating between consecutive reads. At the end of the request a single-clock `done` reports the outcome, with `err` marking a timeout.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A program request produces exactly four write cycles: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (request address, request data).
- R2: An erase request produces exactly six write cycles: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x10).
- R3: Within a write cycle, chip enable is low and output enable is high throughout, and the data driver is on. Address and data are valid for one clock with the write strobe high. The write strobe is then low for exactly WE_CYC clocks, followed by one more clock with the strobe high and the data still driven.
- R4: Each status read keeps chip enable and output enable low and the write strobe high for exactly RD_CYC clocks, with the data driver off, at the request address.
- R5: A program finishes successfully on the first status read whose bit 7 equals bit 7 of the written data, or whose bit 6 equals bit 6 of the previous status read.
- R6: An erase finishes successfully on the first status read whose bit 6 equals bit 6 of the previous status read of the same request; the first status read never ends an erase.
- R7: If MAX_POLLS status reads pass without completion, the request ends with `err` = 1.
- R8: `done` is high for exactly one clock per request, and `err` is 0 at that clock after a successful completion.
- R9: `req_ready` is high only when idle. A `req_valid` while busy is ignored and does not alter the bus cycles of the running request.
- R10: After reset, chip enable, write strobe and output enable are high (inactive), the data driver is off, `done` is low and `req_ready` is high.
- R11: Chip enable returns high for at least one clock between any two bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_erase | input | 1 | 1 = whole-chip erase, 0 = byte program |
| req_addr | input | AW | Target byte address; also the address polled |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-clock end-of-request pulse |
| err | output | 1 | Timeout flag, valid while `done` is high |
| flash_addr | output | AW | Flash address bus |
| flash_dout | output | 8 | Data driven toward the flash |
| flash_doe | output | 1 | Enable for the external data bus driver |
| flash_din | input | 8 | Data read from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
Each fault in the command step counter, the phase counter or the poll judge is visible on the bus within one bus cycle. A bad step shows up as a wrong address or data byte on the next write. A bad phase count shows up as a strobe that is too long or too short. A judge that latches the wrong previous bit 6 finishes an erase one read early or one read late, and that moves `done`. The bench compares every pin on every clock against its own model of the sequence. The early and late cases are separated by erase runs whose last busy read carries bit 6 = 0 or bit 6 = 1. Timeouts are checked by counting the exact number of reads issued before `err` appears.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

   typedef enum logic [2:0] {
      E_IDLE, E_SETUP, E_PULSE, E_HOLD, E_READ
   } eng_state_t;

   typedef enum logic [1:0] {
      S_IDLE, S_ISSUE, S_WAIT, S_FIN
   } seq_state_t;

   typedef struct packed {
      logic [15:0] addr;
      logic [7:0]  data;
   } cmd_word_t;

   localparam logic [15:0] UNLOCK_HI = 16'h5555;
   localparam logic [15:0] UNLOCK_LO = 16'h2AAA;
   localparam int unsigned PROG_WRITES  = 4;
   localparam int unsigned ERASE_WRITES = 6;

   // command word for one step of the unlock/command sequence
   function automatic cmd_word_t cmd_word(input logic erase, input logic [2:0] step);
      cmd_word_t w;
      case (step)
         3'd0:    w = '{addr: UNLOCK_HI, data: 8'hAA};
         3'd1:    w = '{addr: UNLOCK_LO, data: 8'h55};
         3'd2:    w = '{addr: UNLOCK_HI, data: (erase ? 8'h80 : 8'hA0)};
         3'd3:    w = '{addr: UNLOCK_HI, data: 8'hAA};
         3'd4:    w = '{addr: UNLOCK_LO, data: 8'h55};
         default: w = '{addr: UNLOCK_HI, data: 8'h10};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
   import flash_prog_pkg::*;
#(
   parameter int AW     = 19,
   parameter int WE_CYC = 2,
   parameter int RD_CYC = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_write,
   input  logic [AW-1:0] addr_in,
   input  logic [7:0]    data_in,
   output logic          cyc_done,
   output logic [7:0]    rdata,
   output logic [AW-1:0] bus_addr,
   output logic [7:0]    bus_dout,
   output logic          bus_doe,
   input  logic [7:0]    bus_din,
   output logic          ce_n,
   output logic          we_n,
   output logic          oe_n
);
   localparam int MAXC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   eng_state_t    st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= E_IDLE;
         cnt      <= '0;
         ce_n     <= 1'b1;
         we_n     <= 1'b1;
         oe_n     <= 1'b1;
         bus_doe  <= 1'b0;
         bus_addr <= '0;
         bus_dout <= '0;
         rdata    <= '0;
         cyc_done <= 1'b0;
      end else begin
         cyc_done <= 1'b0;
         case (st)
            E_IDLE: if (start) begin
               bus_addr <= addr_in;
               bus_dout <= data_in;
               ce_n     <= 1'b0;
               cnt      <= '0;
               if (is_write) begin
                  bus_doe <= 1'b1;
                  oe_n    <= 1'b1;
                  st      <= E_SETUP;
               end else begin
                  oe_n    <= 1'b0;
                  st      <= E_READ;
               end
            end
            E_SETUP: begin
               we_n <= 1'b0;
               st   <= E_PULSE;
            end
            E_PULSE: begin
               if (cnt == CW'(WE_CYC - 1)) begin
                  we_n <= 1'b1;
                  cnt  <= '0;
                  st   <= E_HOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            E_HOLD: begin
               ce_n     <= 1'b1;
               bus_doe  <= 1'b0;
               cyc_done <= 1'b1;
               st       <= E_IDLE;
            end
            E_READ: begin
               if (cnt == CW'(RD_CYC - 1)) begin
                  rdata    <= bus_din;
                  ce_n     <= 1'b1;
                  oe_n     <= 1'b1;
                  cyc_done <= 1'b1;
                  cnt      <= '0;
                  st       <= E_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // R3: strobe low only inside a selected, driven, non-reading cycle
   a_r3_strobe_context: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ce_n && oe_n && bus_doe));
   // R3: address and data do not move while the strobe is low
   a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> ($stable(bus_addr) && $stable(bus_dout)));
   // R4: never drive the data bus while the flash may be driving it
   a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (!bus_doe && we_n));
   // R11: a finished cycle leaves the chip deselected
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> (ce_n && oe_n && we_n));

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge #(
   parameter bit PROG_TOGGLE = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       sample,
   input  logic       is_erase,
   input  logic       exp_b7,
   input  logic [7:0] rdata,
   output logic       complete
);
   logic prev_b6;
   logic have_prev;
   logic quiet;
   logic prog_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_b6   <= 1'b0;
         have_prev <= 1'b0;
      end else if (clear) begin
         have_prev <= 1'b0;
      end else if (sample) begin
         prev_b6   <= rdata[6];
         have_prev <= 1'b1;
      end
   end

   assign quiet = have_prev && (rdata[6] == prev_b6);

   generate
      if (PROG_TOGGLE) begin : g_prog_both
         assign prog_ok = (rdata[7] == exp_b7) || quiet;
      end else begin : g_prog_b7
         assign prog_ok = (rdata[7] == exp_b7);
      end
   endgenerate

   assign complete = is_erase ? quiet : prog_ok;

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_prog_pkg::*;
#(
   parameter int AW          = 19,
   parameter int WE_CYC      = 2,
   parameter int RD_CYC      = 2,
   parameter int MAX_POLLS   = 64,
   parameter bit PROG_TOGGLE = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_erase,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          req_ready,
   output logic          done,
   output logic          err,
   output logic [AW-1:0] flash_addr,
   output logic [7:0]    flash_dout,
   output logic          flash_doe,
   input  logic [7:0]    flash_din,
   output logic          flash_ce_n,
   output logic          flash_we_n,
   output logic          flash_oe_n
);
   localparam int PW = $clog2(MAX_POLLS + 1);

   generate
      if (AW < 15)        begin : g_chk_aw  $error("AW must hold the unlock addresses"); end
      if (WE_CYC < 1)     begin : g_chk_we  $error("WE_CYC must be at least 1"); end
      if (RD_CYC < 1)     begin : g_chk_rd  $error("RD_CYC must be at least 1"); end
      if (MAX_POLLS < 2)  begin : g_chk_mp  $error("MAX_POLLS must be at least 2"); end
   endgenerate

   seq_state_t    st;
   logic          op_erase;
   logic [AW-1:0] t_addr;
   logic [7:0]    t_data;
   logic [2:0]    step;
   logic          polling;
   logic [PW-1:0] polls;
   logic          err_q;

   cmd_word_t     cw;
   logic [AW-1:0] eng_addr;
   logic [7:0]    eng_data;
   logic          eng_done;
   logic [7:0]    eng_rdata;
   logic          complete;
   logic          sample;
   logic [2:0]    last_step;

   always_comb begin
      cw       = cmd_word(op_erase, step);
      eng_addr = AW'(cw.addr);
      eng_data = cw.data;
      if (polling) begin
         eng_addr = t_addr;
         eng_data = '0;
      end else if (!op_erase && step == 3'(PROG_WRITES - 1)) begin
         eng_addr = t_addr;
         eng_data = t_data;
      end
   end

   assign last_step = op_erase ? 3'(ERASE_WRITES - 1) : 3'(PROG_WRITES - 1);
   assign sample    = (st == S_WAIT) && polling && eng_done;
   assign req_ready = (st == S_IDLE);
   assign done      = (st == S_FIN);
   assign err       = err_q;

   flash_bus_engine #(.AW(AW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (st == S_ISSUE),
      .is_write (!polling),
      .addr_in  (eng_addr),
      .data_in  (eng_data),
      .cyc_done (eng_done),
      .rdata    (eng_rdata),
      .bus_addr (flash_addr),
      .bus_dout (flash_dout),
      .bus_doe  (flash_doe),
      .bus_din  (flash_din),
      .ce_n     (flash_ce_n),
      .we_n     (flash_we_n),
      .oe_n     (flash_oe_n)
   );

   flash_poll_judge #(.PROG_TOGGLE(PROG_TOGGLE)) u_judge (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (st == S_IDLE),
      .sample   (sample),
      .is_erase (op_erase),
      .exp_b7   (t_data[7]),
      .rdata    (eng_rdata),
      .complete (complete)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         op_erase <= 1'b0;
         t_addr   <= '0;
         t_data   <= '0;
         step     <= '0;
         polling  <= 1'b0;
         polls    <= '0;
         err_q    <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               op_erase <= req_erase;
               t_addr   <= req_addr;
               t_data   <= req_data;
               step     <= '0;
               polling  <= 1'b0;
               polls    <= '0;
               err_q    <= 1'b0;
               st       <= S_ISSUE;
            end
            S_ISSUE: st <= S_WAIT;
            S_WAIT: if (eng_done) begin
               if (!polling) begin
                  if (step == last_step) polling <= 1'b1;
                  else                   step    <= step + 1'b1;
                  st <= S_ISSUE;
               end else if (complete) begin
                  st <= S_FIN;
               end else if (polls == PW'(MAX_POLLS - 1)) begin
                  err_q <= 1'b1;
                  st    <= S_FIN;
               end else begin
                  polls <= polls + 1'b1;
                  st    <= S_ISSUE;
               end
            end
            S_FIN: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R8: completion is a single-clock pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: no request is accepted while the bus is in use
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_ce_n |-> !req_ready);
   // R7: the poll counter never passes its budget
   a_r7_poll_budget: assert property (@(posedge clk) disable iff (!rst_n)
      polling |-> (polls < PW'(MAX_POLLS)));

endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 19;
   localparam int WEC  = 3;
   localparam int RDC  = 2;
   localparam int MAXP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_erase = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          req_ready, done, err;
   logic [AW-1:0] flash_addr;
   logic [7:0]    flash_dout;
   logic          flash_doe;
   logic [7:0]    flash_din;
   logic          flash_ce_n, flash_we_n, flash_oe_n;

   int checks = 0;
   int fails  = 0;

   // flash model state
   bit dev_erase;
   int dev_data;
   int dev_busy;
   int rd_idx = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_prog_ctrl #(.AW(AW), .WE_CYC(WEC), .RD_CYC(RDC), .MAX_POLLS(MAXP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
      .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
      .done(done), .err(err), .flash_addr(flash_addr), .flash_dout(flash_dout),
      .flash_doe(flash_doe), .flash_din(flash_din), .flash_ce_n(flash_ce_n),
      .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
   );

   function automatic logic [7:0] dev_val(input int n);
      logic [7:0] v;
      if (n < dev_busy) begin
         v = 8'h00;
         v[7] = dev_erase ? 1'b0 : ~dev_data[7];
         v[6] = n[0];
      end else begin
         v = dev_erase ? 8'hFF : dev_data[7:0];
      end
      return v;
   endfunction

   always_comb flash_din = dev_val(rd_idx);
   always @(posedge flash_oe_n) rd_idx = rd_idx + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // idle-bus clocks before a cycle starts (R11, R9)
   task automatic gap_until_select();
      int k = 0;
      while (flash_ce_n === 1'b1 && k < 6) begin
         chk(flash_we_n === 1'b1 && flash_oe_n === 1'b1 && flash_doe === 1'b0,
             "R11 idle pins in gap", {flash_we_n, flash_oe_n, flash_doe}, 3'b110);
         chk(req_ready === 1'b0 && done === 1'b0, "R9 busy during op",
             {req_ready, done}, 0);
         @(negedge clk);
         k++;
      end
      chk(k >= 1, "R11 gap before cycle", k, 1);
      chk(flash_ce_n === 1'b0, "R11 cycle started", flash_ce_n, 0);
   endtask

   task automatic expect_write(input int a, input int d, input string tag);
      gap_until_select();
      chk(flash_we_n === 1'b1 && flash_oe_n === 1'b1 && flash_doe === 1'b1,
          {"R3 setup ", tag}, {flash_we_n, flash_oe_n, flash_doe}, 3'b111);
      chk(flash_addr == AW'(a) && flash_dout == 8'(d), {tag, " addr/data"},
          {flash_addr, flash_dout}, {a[AW-1:0], d[7:0]});
      for (int i = 0; i < WEC; i++) begin
         @(negedge clk);
         chk(flash_we_n === 1'b0 && flash_ce_n === 1'b0 && flash_oe_n === 1'b1 &&
             flash_doe === 1'b1 && flash_addr == AW'(a) && flash_dout == 8'(d),
             {"R3 strobe low ", tag}, flash_we_n, 0);
      end
      @(negedge clk);
      chk(flash_we_n === 1'b1 && flash_ce_n === 1'b0 && flash_doe === 1'b1 &&
          flash_dout == 8'(d), {"R3 hold ", tag}, {flash_we_n, flash_ce_n, flash_doe}, 3'b101);
      @(negedge clk);
      chk(flash_ce_n === 1'b1, "R11 release after write", flash_ce_n, 1);
   endtask

   task automatic expect_read(input int a);
      gap_until_select();
      for (int i = 0; i < RDC; i++) begin
         chk(flash_ce_n === 1'b0 && flash_oe_n === 1'b0 && flash_we_n === 1'b1 &&
             flash_doe === 1'b0, "R4 read strobes",
             {flash_ce_n, flash_oe_n, flash_we_n, flash_doe}, 4'b0010);
         chk(flash_addr == AW'(a), "R4 poll address", flash_addr, a);
         @(negedge clk);
      end
      chk(flash_ce_n === 1'b1 && flash_oe_n === 1'b1, "R4 read length",
          {flash_ce_n, flash_oe_n}, 2'b11);
   endtask

   task automatic run_op(input bit er, input int a, input int d, input int busy,
                         input bit junk, input string tag);
      int wa[6];
      int wd[6];
      int nw;
      int n = 0;
      int prev = -1;
      bit fin = 1'b0;
      int k = 0;
      logic [7:0] v;
      dev_erase = er; dev_data = d; dev_busy = busy;
      @(negedge clk);
      chk(req_ready === 1'b1, {"R9 ready idle ", tag}, req_ready, 1);
      rd_idx = 0;
      req_valid = 1'b1; req_erase = er; req_addr = AW'(a); req_data = 8'(d);
      @(negedge clk);
      if (junk) begin
         req_erase = ~er; req_addr = AW'(a ^ 5); req_data = ~8'(d);
      end else begin
         req_valid = 1'b0;
      end
      wa = '{32'h5555, 32'h2AAA, 32'h5555, 32'h5555, 32'h2AAA, 32'h5555};
      if (er) begin
         wd = '{32'hAA, 32'h55, 32'h80, 32'hAA, 32'h55, 32'h10};
         nw = 6;
      end else begin
         wd = '{32'hAA, 32'h55, 32'hA0, d, 0, 0};
         wa[3] = a;
         nw = 4;
      end
      for (int i = 0; i < nw; i++)
         expect_write(wa[i], wd[i], er ? "R2 erase cmd" : "R1 program cmd");
      while (!fin && n < MAXP) begin
         v = dev_val(n);
         expect_read(a);
         if (er) fin = (prev == int'(v[6]));
         else    fin = (v[7] == d[7]) || (prev == int'(v[6]));
         prev = int'(v[6]);
         n++;
      end
      while (done !== 1'b1 && k < 6) begin
         chk(flash_ce_n === 1'b1, er ? "R6 no extra read" : "R5 no extra read", flash_ce_n, 1);
         @(negedge clk);
         k++;
      end
      chk(done === 1'b1, er ? "R6 done after expected reads" : "R5 done after expected reads",
          done, 1);
      chk(err === !fin, fin ? "R8 err clear on success" : "R7 timeout err", err, !fin);
      req_valid = 1'b0;
      @(negedge clk);
      chk(done === 1'b0, "R8 single-clock done", done, 0);
      chk(req_ready === 1'b1, "R9 ready after done", req_ready, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(flash_ce_n === 1'b1 && flash_we_n === 1'b1 && flash_oe_n === 1'b1,
          "R10 strobes inactive", {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
      chk(flash_doe === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R10 status",
          {flash_doe, done, req_ready}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(1'b0, 32'h12345, 32'h3C, 3, 1'b0, "prog bit7 low");   // R1 R5
      run_op(1'b0, 32'h00777, 32'hC5, 0, 1'b0, "prog first poll"); // R5
      run_op(1'b1, 32'h00000, 0, 0, 1'b0, "erase immediate");      // R6 first read never ends
      run_op(1'b1, 32'h04000, 0, 3, 1'b0, "erase late stop");      // R2 R6
      run_op(1'b1, 32'h04000, 0, 2, 1'b0, "erase early stop");     // R6
      run_op(1'b0, 32'h7FFFF, 32'h00, 100, 1'b0, "prog timeout");  // R7
      run_op(1'b1, 32'h00010, 0, 100, 1'b0, "erase timeout");      // R7
      run_op(1'b0, 32'h2AAAA, 32'h81, 4, 1'b1, "prog junk req");   // R9
      run_op(1'b0, 32'h00001, 32'h7E, 1, 1'b0, "prog after junk"); // R1 R8
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule